// File: doc/BRIEF.md
# Multi-Level Strap Pad Sampler

This block reads four board strapping pads at power-up and tells four cases apart on each one: a strong pull-down, a weak pull-down, a weak pull-up and a strong pull-up. Each pad can be driven, released and given an internal pull through per-pad control outputs. After a `start_i` pulse the block first drives every pad low for one settle period, so that any stray capacitance drains. It then releases all four pads as inputs with no internal pull and waits a second settle period. Pads are then visited one at a time, from index 0 to index 3. For each pad it takes one sample with no internal pull, enables the internal pull that opposes that sample, waits a settle period, and takes a second sample. Once a pad is done, all of its controls are cleared.

The two samples of each pad form a 2-bit code. The four codes are packed into an 8-bit word. A word with no pull-up on any pad is reported as an error. Otherwise, the nibble of the pin group that is not in use is masked to zero. Settle periods are counted on a one-cycle microsecond tick input.

The state machine has these states:
- `ST_IDLE`: waiting for a start.
- `ST_DISCHARGE`: all pads driven low.
- `ST_FLOAT`: all pads are inputs with no pull.
- `ST_SAMPLE_HI`: first sample of the current pad.
- `ST_PULL`: opposing pull on, settling.
- `ST_SAMPLE_LO`: second sample of the current pad.
- `ST_CHECK`: validate and mask.

Its transitions are:
- start: `ST_IDLE` to `ST_DISCHARGE`.
- drained: `ST_DISCHARGE` to `ST_FLOAT`, when the settle timer expires.
- floated: `ST_FLOAT` to `ST_SAMPLE_HI`, when the timer expires.
- pulled: `ST_SAMPLE_HI` to `ST_PULL`, unconditionally.
- settled: `ST_PULL` to `ST_SAMPLE_LO`, when the timer expires.
- next_pad: `ST_SAMPLE_LO` to `ST_SAMPLE_HI`, when pads remain.
- last_pad: `ST_SAMPLE_LO` to `ST_CHECK`, after pad 3.
- finish: `ST_CHECK` to `ST_IDLE`, with the done pulse.

Top module: `strap_sampler`

## Requirements
- R1: When `start_i` is seen in idle, the next cycle has all four pads with output enable 1 and drive value 0. This discharge phase lasts exactly SETTLE_US microsecond ticks.
- R2: After discharge, all pads have input enable 1, output enable 0 and both pulls 0. This phase lasts exactly SETTLE_US ticks.
- R3: The first sample of each pad is taken with no pull. If it reads 1, the pad's pull-down is enabled; otherwise its pull-up is enabled. No pad ever has both pulls enabled at once.
- R4: After SETTLE_US ticks with the pull on, the second sample is taken. Pad k's code is {first, second}, placed at bits [2k+1:2k] of the raw word. The codes are 00 for a strong pull-down, 01 for a weak pull-down, 10 for a weak pull-up and 11 for a strong pull-up.
- R5: A pad whose sampling is finished has output enable, input enable and both pulls all at 0 while later pads are processed, and after the run.
- R6: If the raw word ANDed with 0xAA is zero, `err_o` is 1 and `cfg_o` is 0.
- R7: Otherwise `err_o` is 0. If the raw word ANDed with 0x0A is nonzero, `cfg_o` is the raw word ANDed with 0x0F; if not, it is the raw word ANDed with 0xF0.
- R8: `done_o` is a one-cycle pulse, once per run. `cfg_o` and `err_o` clear when a start is accepted and otherwise change only with `done_o`.
- R9: `start_i` is ignored while a run is in progress.
- R10: After reset the block is idle: all pad controls are 0, and `done_o`, `err_o` and `cfg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sampling run (accepted only in idle) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| pad_in_i | input | 4 | Pad input levels |
| pad_oe_o | output | 4 | Per-pad output enable |
| pad_drv_o | output | 4 | Per-pad output drive value |
| pad_ie_o | output | 4 | Per-pad input enable |
| pad_pu_o | output | 4 | Per-pad internal pull-up enable |
| pad_pd_o | output | 4 | Per-pad internal pull-down enable |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | No pull-up found on any pad |
| cfg_o | output | 8 | Validated and masked configuration word |

## Verification
The bench sweeps all 256 combinations of the four external pull types. A pad model returns levels that depend on the internal pull the block applies, so a wrong opposing pull or a swapped sample order changes the code. The all-pull-down combinations exercise the error path. Combinations with pull-ups only in the high group, only in the low group, and in both groups tell the two masks and their precedence apart. Phase lengths are measured in ticks, pad release order is watched on every cycle, and some runs receive a stray start in the middle.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int N_PADS = 4;
    localparam int WORD_W = 2 * N_PADS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCHARGE,
        ST_FLOAT,
        ST_SAMPLE_HI,
        ST_PULL,
        ST_SAMPLE_LO,
        ST_CHECK
    } strap_state_t;
endpackage

// File: rtl/strap_timer.sv
module strap_timer #(
    parameter int SETTLE_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(SETTLE_US + 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = en_i && tick_i && (cnt_q == CW'(SETTLE_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(SETTLE_US));
endmodule

// File: rtl/strap_validate.sv
module strap_validate
    import strap_pkg::*;
(
    input  logic [WORD_W-1:0] raw_i,
    output logic [WORD_W-1:0] cfg_o,
    output logic              err_o
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] up_mask;
    logic [WORD_W-1:0] low_mask;
    logic              any_up;
    logic              low_up;

    always_comb begin
        up_mask  = '0;
        low_mask = '0;
        for (int k = 0; k < N_PADS; k++) begin
            up_mask[2*k+1] = 1'b1;
        end
        for (int b = 0; b < HALF; b++) begin
            low_mask[b] = 1'b1;
        end
        any_up = |(raw_i & up_mask);
        low_up = |(raw_i & up_mask & low_mask);
        if (!any_up) begin
            err_o = 1'b1;
            cfg_o = '0;
        end else begin
            err_o = 1'b0;
            cfg_o = low_up ? (raw_i & low_mask) : (raw_i & ~low_mask);
        end
    end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_pkg::*;
#(
    parameter int SETTLE_US = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                us_tick_i,
    input  logic [N_PADS-1:0]   pad_in_i,
    output logic [N_PADS-1:0]   pad_oe_o,
    output logic [N_PADS-1:0]   pad_drv_o,
    output logic [N_PADS-1:0]   pad_ie_o,
    output logic [N_PADS-1:0]   pad_pu_o,
    output logic [N_PADS-1:0]   pad_pd_o,
    output logic                done_o,
    output logic                err_o,
    output logic [WORD_W-1:0]   cfg_o
);
    localparam int IDX_W = $clog2(N_PADS);

    strap_state_t       state_q;
    logic [IDX_W-1:0]   idx_q;
    logic               hi_q;
    logic [WORD_W-1:0]  raw_q;
    logic               tmr_en;
    logic               tmr_exp;
    logic [WORD_W-1:0]  v_cfg;
    logic               v_err;

    assign tmr_en = (state_q == ST_DISCHARGE) || (state_q == ST_FLOAT) ||
                    (state_q == ST_PULL);

    strap_timer #(.SETTLE_US(SETTLE_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tmr_en),
        .tick_i   (us_tick_i),
        .expire_o (tmr_exp)
    );

    strap_validate u_validate (
        .raw_i (raw_q),
        .cfg_o (v_cfg),
        .err_o (v_err)
    );

    // state register and sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            hi_q    <= 1'b0;
            raw_q   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            cfg_o   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_DISCHARGE;
                        idx_q   <= '0;
                        raw_q   <= '0;
                        err_o   <= 1'b0;
                        cfg_o   <= '0;
                    end
                end
                ST_DISCHARGE: begin
                    if (tmr_exp) state_q <= ST_FLOAT;
                end
                ST_FLOAT: begin
                    if (tmr_exp) state_q <= ST_SAMPLE_HI;
                end
                ST_SAMPLE_HI: begin
                    hi_q    <= pad_in_i[idx_q];
                    state_q <= ST_PULL;
                end
                ST_PULL: begin
                    if (tmr_exp) state_q <= ST_SAMPLE_LO;
                end
                ST_SAMPLE_LO: begin
                    raw_q[2*idx_q +: 2] <= {hi_q, pad_in_i[idx_q]};
                    if (idx_q == IDX_W'(N_PADS - 1)) begin
                        state_q <= ST_CHECK;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_SAMPLE_HI;
                    end
                end
                ST_CHECK: begin
                    cfg_o   <= v_cfg;
                    err_o   <= v_err;
                    done_o  <= 1'b1;
                    idx_q   <= '0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // pad control outputs
    always_comb begin
        pad_oe_o  = '0;
        pad_drv_o = '0;
        pad_ie_o  = '0;
        pad_pu_o  = '0;
        pad_pd_o  = '0;
        unique case (state_q)
            ST_DISCHARGE: pad_oe_o = '1;
            ST_FLOAT:     pad_ie_o = '1;
            ST_SAMPLE_HI, ST_PULL, ST_SAMPLE_LO: begin
                for (int k = 0; k < N_PADS; k++) begin
                    pad_ie_o[k] = (k >= int'(idx_q));
                end
                if (state_q != ST_SAMPLE_HI) begin
                    pad_pd_o[idx_q] = hi_q;
                    pad_pu_o[idx_q] = !hi_q;
                end
            end
            default: ;
        endcase
    end

    // R3
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_o & pad_pd_o) == '0);

    // R1
    discharge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (pad_oe_o == '1 && pad_drv_o == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_CHECK) |=> $stable(cfg_o) && $stable(err_o));

    // R6
    err_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> cfg_o == '0);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_CHECK && start_i) |=> state_q != ST_IDLE);
endmodule

// File: tb/strap_sampler_bench.sv
`timescale 1ns/100ps
module strap_sampler_bench;
    localparam int SETTLE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       us_tick = 1'b0;
    logic [3:0] pad_in;
    logic [3:0] oe, drv, ie, pu, pd;
    logic       done, err;
    logic [7:0] cfg;
    logic [7:0] ext = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tph = 0;
    int disch_ticks = 0;
    int float_ticks = 0;
    int done_cnt = 0;
    int mon_bad = 0;

    always #2.5 clk = ~clk;

    strap_sampler #(.SETTLE_US(SETTLE)) u_strap_sampler (
        .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(us_tick),
        .pad_in_i(pad_in), .pad_oe_o(oe), .pad_drv_o(drv), .pad_ie_o(ie),
        .pad_pu_o(pu), .pad_pd_o(pd), .done_o(done), .err_o(err), .cfg_o(cfg)
    );

    // pad model: strong pulls win, weak pulls lose to the internal pull
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if (oe[k]) pad_in[k] = drv[k];
            else case (ext[2*k +: 2])
                2'b00: pad_in[k] = 1'b0;
                2'b11: pad_in[k] = 1'b1;
                2'b01: pad_in[k] = pu[k];
                default: pad_in[k] = !pd[k];
            endcase
        end
    end

    // tick once every four cycles
    always @(negedge clk) begin
        tph = (tph + 1) % 4;
        us_tick = (tph == 0);
    end

    // monitor away from the edge
    always @(negedge clk) begin
        #1;
        if (us_tick && oe == 4'hF && drv == 4'h0) disch_ticks++;
        if (us_tick && ie == 4'hF && oe == 4'h0 && pu == 4'h0 && pd == 4'h0) float_ticks++;
        if (done) done_cnt++;
        for (int k = 0; k < 4; k++) begin
            if (pu[k] && pd[k]) mon_bad++;
            if (pu[k] || pd[k]) begin
                // R3: pull opposes first sample (strong/weak up reads 1 -> pull-down)
                if (pd[k] != ext[2*k+1]) mon_bad++;
                // R5: lower pads released
                for (int j = 0; j < k; j++)
                    if (ie[j] || pu[j] || pd[j] || oe[j]) mon_bad++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] codes, input bit poke);
        logic [7:0] exp_cfg;
        logic       exp_err;
        ext = codes;
        disch_ticks = 0; float_ticks = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        // R8: cleared on accepted start
        if (codes[1:0] == 2'b00) chk("R8 clear", {err, cfg}, 0);
        if (codes[3:0] == 4'h1) chk("R1 discharge", {oe, drv}, 8'hF0);
        for (int i = 0; i < 2000 && !done; i++) begin
            @(negedge clk); #1;
            if (poke && i == 40) start = 1'b1;
            if (poke && i == 41) start = 1'b0;
        end
        start = 1'b0;
        if ((codes & 8'hAA) == 0) begin
            exp_err = 1'b1; exp_cfg = 8'h00;
        end else begin
            exp_err = 1'b0;
            exp_cfg = codes & (((codes & 8'h0A) != 0) ? 8'h0F : 8'hF0);
        end
        if (exp_err) chk("R6 err", {err, cfg}, {exp_err, exp_cfg});
        else         chk("R7 cfg", {err, cfg}, {exp_err, exp_cfg});
        repeat (8) @(negedge clk);
        #1;
        chk("R8 held", {err, cfg}, {exp_err, exp_cfg});
        chk(poke ? "R9 single done" : "R8 one pulse", done_cnt, 1);
        if (codes[2:0] == 3'b010) begin
            chk("R1 ticks", disch_ticks, SETTLE);
            chk("R2 ticks", float_ticks, SETTLE);
            chk("R5 released", {oe, ie, pu, pd}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset", {oe, drv, ie, pu, pd, done, err, cfg}, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 256; c++) begin
            run_case(8'(c), (c % 37) == 5);
        end
        // R4: placement spot checks with mixed strengths
        run_case(8'h02, 1'b0); chk("R4 pad0 weak up", cfg, 8'h02);
        run_case(8'h20, 1'b0); chk("R4 pad2 weak up", cfg, 8'h20);
        run_case(8'h1B, 1'b0); chk("R4 pads0/1", cfg, 8'h0B);
        checks++;
        if (mon_bad != 0) begin
            errors++;
            $display("FAIL R3/R5 monitor: actual %0d expected 0", mon_bad);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule